// File: doc/BRIEF.md
# Key-Locked Watchdog Timer

This block is a watchdog timer reached through a small 32-bit register port. A 31-bit up-counter moves forward by one on each cycle in which a low-frequency tick strobe is high, provided at least one of two enable bits is set. A four-bit prescale field picks which slice of the counter is taken as a 16-bit scaled count, and that scaled count is compared with a 16-bit limit. When the scaled count is at or above the limit, the block sets a sticky interrupt-pending bit. Depending on the configuration, it can also clear the counter and emit a one-cycle reset request.

Each write to a protected register (configuration, counter, feed, limit) must be preceded by a write of a key value to the key register. That unlock serves exactly one protected write. Software keeps the watchdog from expiring by writing a second magic value to the feed register, which clears the counter. The port has zero wait states. A read presents its data on the cycle after the request.

Top module: `kwd_top`

## Requirements
- R1: After reset the configuration reads 0, the limit (offset 0x20) reads 0xBEEF, the key register (offset 0x1C) reads 0, the counter (offset 0x08) reads 0, and `irq` and `rst_req` are low.
- R2: An unlocked write to offset 0x08 loads bits [30:0] of the write data into the counter and discards bit 31. A read of 0x08 returns the counter with bit 31 as 0.
- R3: The counter rises by one on each cycle with `tick` high while configuration bit 12 (run always) or bit 13 (run while awake) is set. It holds while both bits are clear, and it wraps from 0x7FFFFFFF to 0.
- R4: Writing the key value to 0x1C sets the unlock flag, which reads back as bit 0 of 0x1C; a key write of any other value leaves the flag unchanged. While the flag is clear, writes to 0x00, 0x08, 0x18 and 0x20 are ignored. Any write to one of these four offsets clears the flag.
- R5: An unlocked write of the feed value to 0x18 clears the counter. Any other value leaves the counter as it was but still clears the unlock flag. Reads of 0x18 return 0.
- R6: Offset 0x10 reads the counter shifted right by configuration bits [3:0], truncated to 16 bits. Writes to it change nothing and do not clear the unlock flag.
- R7: When the scaled count is greater than or equal to the 16-bit limit, configuration bit 28 and `irq` are 1 on the next cycle. If configuration bit 9 (zero on match) is set, the counter is also 0 on the next cycle.
- R8: `irq` always equals configuration bit 28. The bit stays set until an unlocked configuration write with bit 28 at 0 lands in a cycle when the compare is false.
- R9: If configuration bit 8 (reset enable) is set, `rst_req` is high for exactly one cycle, in the cycle after the compare turns from false to true.
- R10: Read data is presented on the cycle after a read request and holds until the next read. Reserved configuration bits read 0. Reads of undefined offsets return 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Low-frequency count strobe |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| irq | output | 1 | Interrupt, equal to the pending bit |
| rst_req | output | 1 | One-cycle reset request |

## Verification
Every register effect of a write, and every compare effect (pending bit, counter clear, reset pulse), appears on the cycle after the causing edge. Read data likewise appears on the cycle after the read request. The bench drives inputs on the falling edge and advances its behavioural model on the rising edge. It compares `irq`, `rst_req` and `bus_rdata` with the model at every falling edge, so each result is sampled a half cycle after the edge that must produce it. Directed reads add fixed expected values wherever the state follows directly from the requirements.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned SCALE_W = 4;

  localparam int unsigned OFF_CFG    = 'h00;
  localparam int unsigned OFF_COUNT  = 'h08;
  localparam int unsigned OFF_SCALED = 'h10;
  localparam int unsigned OFF_FEED   = 'h18;
  localparam int unsigned OFF_KEY    = 'h1C;
  localparam int unsigned OFF_LIMIT  = 'h20;

  localparam int unsigned CFG_SCALE_LSB = 0;
  localparam int unsigned CFG_RSTEN     = 8;
  localparam int unsigned CFG_ZERO      = 9;
  localparam int unsigned CFG_RUN_ALL   = 12;
  localparam int unsigned CFG_RUN_AWAKE = 13;
  localparam int unsigned CFG_PEND      = 28;

  typedef struct packed {
    logic               pend;
    logic               run_awake;
    logic               run_all;
    logic               zero_on_hit;
    logic               rst_en;
    logic [SCALE_W-1:0] scale;
  } cfg_t;
endpackage

// File: rtl/kwd_unlock.sv
module kwd_unlock (
  input  logic clk,
  input  logic rst,
  input  logic key_wr,
  input  logic key_ok,
  input  logic prot_wr,
  output logic unlocked
);
  always_ff @(posedge clk) begin
    if (rst)                  unlocked <= 1'b0;
    else if (prot_wr)         unlocked <= 1'b0;
    else if (key_wr && key_ok) unlocked <= 1'b1;
  end
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
  parameter int unsigned CNT_W = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clear,
  input  logic             step,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)        count <= '0;
    else if (load)  count <= load_val;
    else if (clear) count <= '0;
    else if (step)  count <= count + 1'b1;
  end
endmodule

// File: rtl/kwd_cmp.sv
module kwd_cmp #(
  parameter int unsigned CNT_W   = 31,
  parameter int unsigned CMP_W   = 16,
  parameter int unsigned SCALE_W = 4
) (
  input  logic [CNT_W-1:0]   count,
  input  logic [SCALE_W-1:0] scale,
  input  logic [CMP_W-1:0]   limit,
  output logic [CMP_W-1:0]   scaled,
  output logic               hit
);
  localparam int unsigned NSCALE = 1 << SCALE_W;
  localparam int unsigned EXT_W  = CNT_W + NSCALE + CMP_W;

  logic [EXT_W-1:0] ext;
  logic [CMP_W-1:0] cand [NSCALE];

  assign ext = EXT_W'(count);

  for (genvar s = 0; s < NSCALE; s++) begin : g_slice
    assign cand[s] = ext[s +: CMP_W];
  end

  assign scaled = cand[scale];
  assign hit    = (scaled >= limit);
endmodule

// File: rtl/kwd_top.sv
module kwd_top
  import kwd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned CNT_W     = 31,
  parameter int unsigned CMP_W     = 16,
  parameter logic [31:0] KEY_VAL   = 32'h0051F15E,
  parameter logic [31:0] FEED_VAL  = 32'h0D09F00D,
  parameter logic [15:0] LIMIT_RST = 16'hBEEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              rst_req
);
  localparam logic [ADDR_W-1:0] A_CFG    = ADDR_W'(OFF_CFG);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFF_COUNT);
  localparam logic [ADDR_W-1:0] A_SCALED = ADDR_W'(OFF_SCALED);
  localparam logic [ADDR_W-1:0] A_FEED   = ADDR_W'(OFF_FEED);
  localparam logic [ADDR_W-1:0] A_KEY    = ADDR_W'(OFF_KEY);
  localparam logic [ADDR_W-1:0] A_LIMIT  = ADDR_W'(OFF_LIMIT);

  logic wr, rd;
  logic sel_cfg, sel_cnt, sel_feed, sel_key, sel_lim, prot_sel;
  logic unlocked, prot_wr, wr_ok;
  logic cfg_wr, cnt_wr, lim_wr, feed_ok;
  logic run, hit, hit_q;
  cfg_t cfg_q;
  logic [CMP_W-1:0] limit_q, scaled;
  logic [CNT_W-1:0] count;
  logic [31:0] rd_mux;

  assign wr       = bus_valid &  bus_write;
  assign rd       = bus_valid & ~bus_write;
  assign sel_cfg  = (bus_addr == A_CFG);
  assign sel_cnt  = (bus_addr == A_COUNT);
  assign sel_feed = (bus_addr == A_FEED);
  assign sel_key  = (bus_addr == A_KEY);
  assign sel_lim  = (bus_addr == A_LIMIT);
  assign prot_sel = sel_cfg | sel_cnt | sel_feed | sel_lim;

  assign prot_wr  = wr & prot_sel;
  assign wr_ok    = prot_wr & unlocked;
  assign cfg_wr   = wr_ok & sel_cfg;
  assign cnt_wr   = wr_ok & sel_cnt;
  assign lim_wr   = wr_ok & sel_lim;
  assign feed_ok  = wr_ok & sel_feed & (bus_wdata == FEED_VAL);

  kwd_unlock u_unlock (
    .clk      (clk),
    .rst      (rst),
    .key_wr   (wr & sel_key),
    .key_ok   (bus_wdata == KEY_VAL),
    .prot_wr  (prot_wr),
    .unlocked (unlocked)
  );

  assign run = cfg_q.run_all | cfg_q.run_awake;

  kwd_counter #(.CNT_W(CNT_W)) u_counter (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_wr),
    .load_val (bus_wdata[CNT_W-1:0]),
    .clear    (feed_ok | (hit & cfg_q.zero_on_hit)),
    .step     (run & tick),
    .count    (count)
  );

  kwd_cmp #(.CNT_W(CNT_W), .CMP_W(CMP_W), .SCALE_W(SCALE_W)) u_cmp (
    .count  (count),
    .scale  (cfg_q.scale),
    .limit  (limit_q),
    .scaled (scaled),
    .hit    (hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else begin
      if (cfg_wr) begin
        cfg_q.scale       <= bus_wdata[CFG_SCALE_LSB +: SCALE_W];
        cfg_q.rst_en      <= bus_wdata[CFG_RSTEN];
        cfg_q.zero_on_hit <= bus_wdata[CFG_ZERO];
        cfg_q.run_all     <= bus_wdata[CFG_RUN_ALL];
        cfg_q.run_awake   <= bus_wdata[CFG_RUN_AWAKE];
      end
      cfg_q.pend <= (cfg_wr ? bus_wdata[CFG_PEND] : cfg_q.pend) | hit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         limit_q <= LIMIT_RST[CMP_W-1:0];
    else if (lim_wr) limit_q <= bus_wdata[CMP_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q   <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      hit_q   <= hit;
      rst_req <= hit & ~hit_q & cfg_q.rst_en;
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (1'b1)
      sel_cfg: begin
        rd_mux[CFG_SCALE_LSB +: SCALE_W] = cfg_q.scale;
        rd_mux[CFG_RSTEN]     = cfg_q.rst_en;
        rd_mux[CFG_ZERO]      = cfg_q.zero_on_hit;
        rd_mux[CFG_RUN_ALL]   = cfg_q.run_all;
        rd_mux[CFG_RUN_AWAKE] = cfg_q.run_awake;
        rd_mux[CFG_PEND]      = cfg_q.pend;
      end
      sel_cnt:                 rd_mux = 32'(count);
      (bus_addr == A_SCALED):  rd_mux = 32'(scaled);
      sel_key:                 rd_mux = 32'(unlocked);
      sel_lim:                 rd_mux = 32'(limit_q);
      default:                 rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_mux;
  end

  assign irq = cfg_q.pend;
endmodule

// File: rtl/kwd_chk.sv
module kwd_chk #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned CNT_W    = 31,
  parameter logic [31:0] FEED_VAL = 32'h0D09F00D
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              unlocked,
  input logic              hit,
  input logic              run,
  input logic              zero_on_hit,
  input logic [CNT_W-1:0]  count,
  input logic              irq,
  input logic              rst_req
);
  logic wr, prot;
  assign wr   = bus_valid && bus_write;
  assign prot = (bus_addr == ADDR_W'('h00)) || (bus_addr == ADDR_W'('h08)) ||
                (bus_addr == ADDR_W'('h18)) || (bus_addr == ADDR_W'('h20));

  a_r4_single_use: assert property (@(posedge clk) disable iff (rst)
    unlocked && wr && prot |=> !unlocked);

  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    unlocked && wr && bus_addr == ADDR_W'('h08) |=> count == $past(bus_wdata[CNT_W-1:0]));

  a_r5_feed_clear: assert property (@(posedge clk) disable iff (rst)
    unlocked && wr && bus_addr == ADDR_W'('h18) && bus_wdata == FEED_VAL |=> count == '0);

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !run && !wr && !(hit && zero_on_hit) |=> $stable(count));

  a_r7_hit_pend: assert property (@(posedge clk) disable iff (rst)
    hit |=> irq);

  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    irq && !(unlocked && wr && bus_addr == ADDR_W'('h00)) |=> irq);

  a_r9_pulse: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);
endmodule

bind kwd_top kwd_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .FEED_VAL(FEED_VAL)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_valid   (bus_valid),
  .bus_write   (bus_write),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .unlocked    (unlocked),
  .hit         (hit),
  .run         (run),
  .zero_on_hit (cfg_q.zero_on_hit),
  .count       (count),
  .irq         (irq),
  .rst_req     (rst_req)
);

// File: tb/kwd_top_bench.sv
module kwd_top_bench;
  localparam logic [31:0] KEY  = 32'h0051F15E;
  localparam logic [31:0] FEED = 32'h0D09F00D;
  localparam logic [7:0] O_CFG = 8'h00, O_CNT = 8'h08, O_SCL = 8'h10,
                         O_FEED = 8'h18, O_KEY = 8'h1C, O_LIM = 8'h20;
  localparam longint MASK = 64'h7FFF_FFFF;

  logic clk = 0, rst = 1, tick = 0;
  logic bus_valid = 0, bus_write = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic irq, rst_req;

  int total = 0, bad = 0;
  int tick_every = 0, tick_cnt = 0;
  bit done = 0;

  kwd_top u_kwd_top (
    .clk(clk), .rst(rst), .tick(tick), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .rst_req(rst_req)
  );

  always #10 clk = ~clk;

  // behavioural reference model
  longint m_cnt, m_lim, m_rdata;
  int m_scale;
  bit m_rsten, m_zero, m_all, m_awake, m_pend, m_unl, m_rst, m_prev;

  always @(posedge clk) begin
    longint sc, nc;
    bit h, w, r, p, cw, old_rsten;
    logic [31:0] v;
    if (rst) begin
      m_cnt = 0; m_lim = 'hBEEF; m_rdata = 0; m_scale = 0;
      m_rsten = 0; m_zero = 0; m_all = 0; m_awake = 0; m_pend = 0;
      m_unl = 0; m_rst = 0; m_prev = 0;
    end else begin
      w = bus_valid && bus_write;
      r = bus_valid && !bus_write;
      sc = (m_cnt >> m_scale) & 'hFFFF;
      h = (sc >= m_lim);
      if (r) begin
        case (bus_addr)
          O_CFG: begin
            v = 0; v[3:0] = 4'(m_scale); v[8] = m_rsten; v[9] = m_zero;
            v[12] = m_all; v[13] = m_awake; v[28] = m_pend;
            m_rdata = v;
          end
          O_CNT:   m_rdata = m_cnt;
          O_SCL:   m_rdata = sc;
          O_KEY:   m_rdata = m_unl;
          O_LIM:   m_rdata = m_lim;
          default: m_rdata = 0;
        endcase
      end
      old_rsten = m_rsten;
      nc = m_cnt;
      if ((m_all || m_awake) && tick) nc = (m_cnt + 1) & MASK;
      if (h && m_zero) nc = 0;
      p = (bus_addr == O_CFG) || (bus_addr == O_CNT) || (bus_addr == O_FEED) || (bus_addr == O_LIM);
      cw = 0;
      if (w && p) begin
        if (m_unl) begin
          case (bus_addr)
            O_CNT:  nc = longint'(bus_wdata) & MASK;
            O_FEED: if (bus_wdata == FEED) nc = 0;
            O_LIM:  m_lim = bus_wdata[15:0];
            default: begin
              cw = 1;
              m_scale = bus_wdata[3:0]; m_rsten = bus_wdata[8]; m_zero = bus_wdata[9];
              m_all = bus_wdata[12]; m_awake = bus_wdata[13];
            end
          endcase
        end
        m_unl = 0;
      end else if (w && bus_addr == O_KEY && bus_wdata == KEY) begin
        m_unl = 1;
      end
      m_pend = (cw ? bus_wdata[28] : m_pend) | h;
      m_rst = h && !m_prev && old_rsten;
      m_prev = h;
      m_cnt = nc;
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // continuous comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R8 irq", irq, m_pend);
      check("R9 rst_req", rst_req, m_rst);
      check("R10 rdata", bus_rdata, m_rdata);
    end
  end

  always @(negedge clk) begin
    if (tick_every == 0) tick = 0;
    else begin
      tick_cnt = (tick_cnt + 1) % tick_every;
      tick = (tick_cnt == 0);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic uwr(input logic [7:0] a, input logic [31:0] d);
    wr(O_KEY, KEY);
    wr(a, d);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] q);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    q = bus_rdata;
  endtask

  task automatic rdx(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] q;
    rd(a, q);
    check(tag, q, exp);
  endtask

  task automatic rdm(input string tag, input logic [7:0] a);
    logic [31:0] q;
    rd(a, q);
    check(tag, q, m_rdata);
  endtask

  task automatic summary();
    done = 1;
    $display("%0d/%0d checks passed", total - bad, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    logic [31:0] v1;
    int n;
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1 irq", irq, 0);
    check("R1 rst_req", rst_req, 0);
    rdx("R1 cfg", O_CFG, 0);
    rdx("R1 limit", O_LIM, 32'hBEEF);
    rdx("R1 key", O_KEY, 0);
    rdx("R1 count", O_CNT, 0);

    wr(O_LIM, 5);
    rdx("R4 locked limit", O_LIM, 32'hBEEF);
    wr(O_KEY, 32'h1234);
    rdx("R4 wrong key", O_KEY, 0);
    wr(O_KEY, KEY);
    rdx("R4 key set", O_KEY, 1);
    wr(O_SCL, 32'h1234);
    rdx("R6 scaled write keeps unlock", O_KEY, 1);
    wr(O_LIM, 32'h0001_0020);
    rdx("R4 unlock consumed", O_KEY, 0);
    rdx("R7 limit 16 bits", O_LIM, 32'h20);

    uwr(O_CNT, 32'hFFFF_FFF0);
    rdx("R2 msb dropped", O_CNT, 32'h7FFF_FFF0);
    rdx("R6 scaled scale0", O_SCL, 32'hFFF0);
    check("R7 irq on hit", irq, 1);
    rdx("R8 pend in cfg", O_CFG, 32'h1000_0000);
    uwr(O_CNT, 0);
    uwr(O_CFG, 0);
    rdx("R8 pend cleared", O_CFG, 0);

    uwr(O_CFG, 32'h0000_1002);
    tick_every = 1;
    repeat (40) @(negedge clk);
    rdm("R3 counting", O_CNT);
    rdm("R6 scaled scale2", O_SCL);
    n = 0;
    while (!irq && n < 400) begin @(negedge clk); n++; end
    check("R7 irq after count", irq, 1);

    tick_every = 0;
    repeat (2) @(negedge clk);
    rd(O_CNT, v1);
    uwr(O_FEED, 32'h1234);
    rdx("R5 bad feed consumes", O_KEY, 0);
    rdx("R5 bad feed keeps count", O_CNT, v1);
    uwr(O_FEED, FEED);
    rdx("R5 feed clears", O_CNT, 0);
    rdx("R5 feed reads 0", O_FEED, 0);
    rdx("R8 sticky", O_CFG, 32'h1000_1002);

    uwr(O_CFG, 32'h0000_1302);
    rdx("R8 cleared", O_CFG, 32'h0000_1302);
    tick_every = 1;
    n = 0;
    while (!rst_req && n < 400) begin @(negedge clk); n++; end
    check("R9 rst_req seen", rst_req, 1);
    @(negedge clk);
    check("R9 one cycle", rst_req, 0);
    check("R7 zero on hit", irq, 1);
    rdm("R7 count restarted", O_CNT);
    tick_every = 3;
    repeat (600) @(negedge clk);
    rdm("R3 slow tick", O_CNT);

    tick_every = 1;
    uwr(O_CFG, 0);
    repeat (2) @(negedge clk);
    rd(O_CNT, v1);
    repeat (20) @(negedge clk);
    rdx("R3 hold disabled", O_CNT, v1);
    uwr(O_CFG, 32'h0000_2000);
    repeat (10) @(negedge clk);
    rdm("R3 awake enable", O_CNT);
    uwr(O_CNT, 32'h7FFF_FFFE);
    repeat (3) @(negedge clk);
    rdm("R3 wrap", O_CNT);

    rdx("R10 undefined read", 8'h04, 0);
    wr(8'h24, 32'hFFFF_FFFF);
    rdm("R10 undefined write", O_CFG);
    rdm("R10 limit intact", O_LIM);
    tick_every = 0;
    repeat (3) @(negedge clk);
    summary();
  end
endmodule